// File: doc/BRIEF.md
# SPI register access bridge

This block is an SPI slave that turns a short serial framing into single-cycle accesses on a parallel register port. A master opens one chip-select window per access and clocks 48 bits in SPI mode 0. The first 8 bits are a command byte, the next 8 bits are a register offset, and the last 32 bits are a data word. The bridge decides from the command byte whether the access is legal. It then issues a read strobe or a write strobe, or it raises an error pulse.

All inputs are synchronous to `clk`. The serial clock is sampled as data, so `clk` must run several times faster than `sclk`. Every `sclk` phase, high or low, must last at least 4 `clk` cycles.

For a read, the word is fetched as soon as the header is complete and is shifted out on `miso` during the data phase. For a write, the word is committed only once the full frame has arrived.

Top module: `spi_regbridge`

## Requirements
- R1: While `rst_n` is low and right after reset, `reg_rd`, `reg_wr`, `acc_err` and `miso` are all 0.
- R2: Bits are sampled on rising `sclk` edges, most significant bit first. The command byte is laid out as follows: bits 7:5 are the block number, bit 4 is the direction (1 means write, 0 means read), and bits 3:0 are the sub-block. The second byte is the offset. The data word travels from bit 31 down to bit 0. `reg_blk`, `reg_sub` and `reg_off` carry these fields whenever a strobe is high.
- R3: Blocks 0 and 6 are illegal. Block 1 accepts sub-blocks 0 to PORT_SUBS-1 and sub-block HOST_SUB, and rejects every other sub-block. Blocks 2, 3, 4, 5 and 7 accept any sub-block.
- R4: For a legal read, `reg_rd` is high for exactly one `clk` cycle. That cycle is the one that follows the first `clk` edge at which the 16th rising `sclk` level is seen.
- R5: `reg_rdata` is captured one cycle after `reg_rd`. Its bit 31 appears on `miso` before the 17th rising `sclk` edge. Each following bit appears after each later falling edge.
- R6: For a legal write, `reg_wr` pulses for one cycle after the 48th bit, with `reg_wdata` equal to the received word. This happens exactly once per frame.
- R7: A frame that ends before the 48th bit produces no write strobe.
- R8: A rejected access produces no strobe. `acc_err` pulses for one cycle at the point where a read strobe would have been issued. A rejected read returns all ones on `miso`.
- R9: `miso` is 0 while `cs_n` is high, during the header bits, and throughout the data phase of a write.
- R10: Bits clocked beyond the 48th are ignored and cause no further strobe.
- R11: `reg_rd` and `reg_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial signals |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, 0 when idle |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_blk | output | 3 | Selected block number |
| reg_sub | output | 4 | Selected sub-block number |
| reg_off | output | 8 | Register offset |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, sampled one cycle after `reg_rd` |
| acc_err | output | 1 | One-cycle pulse on a rejected access |

## Verification
The bench builds the bridge with PORT_SUBS = 5 and HOST_SUB = 6. With these values, block 1 accepts sub-blocks 0 to 4 and 6. Sub-block 5, which sits between the port range and the host sub-block, is rejected, and so are sub-blocks 7 to 15. A sweep of reads over all 128 block and sub-block pairs therefore covers the whole legality rule.

The serial clock runs with 4-cycle phases, which is the shortest the bridge allows. This puts the read fetch right at its timing margin before the first data bit is due. Short frames and overlong frames exercise the write commit point.

// File: rtl/spi_regbridge.sv
module spi_regbridge #(
  parameter int PORT_SUBS = 5,
  parameter int HOST_SUB  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        reg_rd,
  output logic        reg_wr,
  output logic [2:0]  reg_blk,
  output logic [3:0]  reg_sub,
  output logic [7:0]  reg_off,
  output logic [31:0] reg_wdata,
  input  logic [31:0] reg_rdata,
  output logic        acc_err
);
  localparam int HDR_BITS   = 16;
  localparam int FRAME_BITS = HDR_BITS + 32;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic             sclk_q;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      rx_sr, tx_sr;
  logic [15:0]      hdr;
  logic             hdr_ok, rd_pend;

  function automatic logic legal(input logic [2:0] b, input logic [3:0] s);
    case (b)
      3'd0, 3'd6: legal = 1'b0;
      3'd1:       legal = (int'(s) < PORT_SUBS) || (int'(s) == HOST_SUB);
      default:    legal = 1'b1;
    endcase
  endfunction

  wire        rise    = ~cs_n & sclk & ~sclk_q;
  wire        fall    = ~cs_n & ~sclk & sclk_q;
  wire [31:0] rx_next = {rx_sr[30:0], mosi};
  wire        at_hdr  = rise && (cnt == CNT_W'(HDR_BITS - 1));
  wire        at_end  = rise && (cnt == CNT_W'(FRAME_BITS - 1));
  wire        nxt_ok  = legal(rx_next[15:13], rx_next[11:8]);
  wire        nxt_wr  = rx_next[12];

  assign miso    = ~cs_n & tx_sr[31];
  assign reg_blk = hdr[15:13];
  assign reg_sub = hdr[11:8];
  assign reg_off = hdr[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cnt       <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      hdr       <= '0;
      hdr_ok    <= 1'b0;
      rd_pend   <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      reg_rd  <= 1'b0;
      reg_wr  <= 1'b0;
      acc_err <= 1'b0;
      rd_pend <= reg_rd;
      if (cs_n) begin
        cnt   <= '0;
        tx_sr <= '0;
      end else begin
        if (rise) begin
          rx_sr <= rx_next;
          if (cnt != CNT_W'(FRAME_BITS)) cnt <= cnt + 1'b1;
        end
        if (at_hdr) begin
          hdr     <= rx_next[15:0];
          hdr_ok  <= nxt_ok;
          reg_rd  <= nxt_ok & ~nxt_wr;
          acc_err <= ~nxt_ok;
          if (!nxt_ok && !nxt_wr) tx_sr <= '1;
        end
        if (at_end && hdr_ok && hdr[12]) begin
          reg_wr    <= 1'b1;
          reg_wdata <= rx_next;
        end
        if (rd_pend)
          tx_sr <= reg_rdata;
        else if (fall && cnt > CNT_W'(HDR_BITS))
          tx_sr <= {tx_sr[30:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_regbridge_chk.sv
module spi_regbridge_chk #(
  parameter int PORT_SUBS = 5,
  parameter int HOST_SUB  = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [2:0] reg_blk,
  input logic [3:0] reg_sub,
  input logic       acc_err
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_rd && reg_wr)); // R11
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R6
  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> $past(!cs_n)); // R6
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) acc_err |-> (!reg_rd && !reg_wr)); // R8
  AST_STB_BLOCK_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |-> (reg_blk != 3'd0 && reg_blk != 3'd6)); // R3
  AST_STB_PORT_SUB_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && reg_blk == 3'd1) |-> (int'(reg_sub) < PORT_SUBS || int'(reg_sub) == HOST_SUB)); // R3
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ($past(cs_n) && cs_n) |-> !miso); // R9
endmodule

bind spi_regbridge spi_regbridge_chk #(.PORT_SUBS(PORT_SUBS), .HOST_SUB(HOST_SUB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_blk(reg_blk), .reg_sub(reg_sub), .acc_err(acc_err)
);

// File: tb/spi_regbridge_tb.sv
`timescale 1ns/1ps
module spi_regbridge_tb;
  localparam int H = 4;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_rd, reg_wr, acc_err;
  logic [2:0] reg_blk;
  logic [3:0] reg_sub;
  logic [7:0] reg_off;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit exp_rd[int], exp_wr[int], exp_err[int];
  logic [2:0] e_blk; logic [3:0] e_sub; logic [7:0] e_off; logic [31:0] e_word;

  always #2 clk = ~clk;

  spi_regbridge u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_blk(reg_blk), .reg_sub(reg_sub),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_err(acc_err)
  );

  function automatic logic [31:0] word_of(input logic [2:0] b, input logic [3:0] s, input logic [7:0] o);
    return {o, 1'b0, b, s, ~o, o ^ 8'h3C};
  endfunction

  assign reg_rdata = word_of(reg_blk, reg_sub, reg_off);

  function automatic bit ok_of(input logic [2:0] b, input logic [3:0] s);
    if (b == 3'd1) return (s inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6});
    return (b inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd7});
  endfunction

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(reg_rd == exp_rd.exists(cyc), "R4", 32'(reg_rd), 32'(exp_rd.exists(cyc)));
      chk(reg_wr == exp_wr.exists(cyc), "R6", 32'(reg_wr), 32'(exp_wr.exists(cyc)));
      chk(acc_err == exp_err.exists(cyc), "R8", 32'(acc_err), 32'(exp_err.exists(cyc)));
      if (reg_rd || reg_wr)
        chk({reg_blk, reg_sub, reg_off} == {e_blk, e_sub, e_off}, "R2",
            32'({reg_blk, reg_sub, reg_off}), 32'({e_blk, e_sub, e_off}));
      if (reg_wr) chk(reg_wdata == e_word, "R6", reg_wdata, e_word);
      if (cs_n) chk(miso == 1'b0, "R9", 32'(miso), 0);
      if (cyc >= LIMIT) begin
        chk(1'b0, "watchdog", cyc, LIMIT);
        summary();
      end
    end
  end

  task automatic xfer(input logic [2:0] b, input logic d, input logic [3:0] s,
                      input logic [7:0] o, input logic [31:0] w, input int nbits);
    logic [47:0] fr;
    logic [31:0] rw;
    bit ok;
    string tag;
    fr = {b, d, s, o, w};
    ok = ok_of(b, s);
    rw = d ? 32'h0 : (ok ? word_of(b, s, o) : 32'hFFFF_FFFF);
    tag = (d || ok) ? "R5" : "R8";
    e_blk = b; e_sub = s; e_off = o; e_word = w;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 48) ? fr[47-i] : i[0];
      repeat (H) @(negedge clk);
      if (i < 16) chk(miso == 1'b0, "R9", 32'(miso), 0);
      else if (i < 48) chk(miso == rw[47-i], d ? "R9" : tag, 32'(miso), 32'(rw[47-i]));
      sclk = 1'b1;
      if (i == 15) begin
        if (ok && !d) exp_rd[cyc+1] = 1;
        if (!ok) exp_err[cyc+1] = 1;
      end
      if (i == 47 && ok && d) exp_wr[cyc+1] = 1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({reg_rd, reg_wr, acc_err, miso} == 4'b0, "R1", 32'({reg_rd, reg_wr, acc_err, miso}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({reg_rd, reg_wr, acc_err, miso} == 4'b0, "R1", 32'({reg_rd, reg_wr, acc_err, miso}), 0);

    xfer(3'd1, 1'b1, 4'd0, 8'h19, 32'hA5C3_1E77, 48);   // R2 R6 legal write
    xfer(3'd1, 1'b0, 4'd6, 8'h00, 32'h0, 48);           // R4 R5 host sub-block read
    xfer(3'd7, 1'b0, 4'd0, 8'h18, 32'h0, 48);           // R5
    xfer(3'd3, 1'b0, 4'd15, 8'hC2, 32'h0, 48);          // R3 any sub-block
    xfer(3'd1, 1'b1, 4'd4, 8'h80, 32'h0123_4567, 48);   // R6
    xfer(3'd0, 1'b1, 4'd0, 8'h01, 32'hDEAD_BEEF, 48);   // R8 rejected write
    xfer(3'd6, 1'b0, 4'd2, 8'h02, 32'h0, 48);           // R8 rejected read, all ones
    xfer(3'd1, 1'b0, 4'd5, 8'h05, 32'h0, 48);           // R3 gap sub-block
    xfer(3'd1, 1'b1, 4'd7, 8'h05, 32'h5555_AAAA, 48);   // R3
    xfer(3'd2, 1'b1, 4'd9, 8'h33, 32'hFFFF_0000, 40);   // R7 cut in data phase
    xfer(3'd5, 1'b1, 4'd1, 8'h44, 32'h1234_5678, 12);   // R7 cut in header
    xfer(3'd4, 1'b0, 4'd3, 8'h7E, 32'h0, 16);           // R4 read strobe with header only
    xfer(3'd2, 1'b1, 4'd8, 8'hF0, 32'h8000_0001, 56);   // R10 overlong frame
    xfer(3'd5, 1'b0, 4'd11, 8'hAB, 32'h0, 60);          // R10 overlong read
    // R3 sweep over every block and sub-block pair
    for (int bb = 0; bb < 8; bb++)
      for (int ss = 0; ss < 16; ss++)
        xfer(3'(bb), 1'b0, 4'(ss), 8'(bb * 16 + ss), 32'h0, 48);
    repeat (10) @(negedge clk);
    summary();
  end
endmodule